// File: doc/BRIEF.md
# Single-Cell Battery Protection Mode Controller

This block is the digital decision core of a protector for one lithium-ion cell. Analog comparators sample the cell voltage against several thresholds and sample a current-sense node against several current thresholds. These comparators sit outside the block. The block receives their flags, a charger-present flag and a load-present flag. From these it decides which of two power switches may conduct: the charge path and the discharge path. It also controls a pull-up and a pull-down on the sense node, and a standby output that cuts internal bias.

Every fault has a detection delay, and every recovery has a release delay. A delay is counted in pulses of a single timebase tick, so the integrating design sets the real time by choosing the tick rate and the parameter counts. A condition must hold without a break for its full count. Each mode looks only at the detectors that matter in that mode. During over-charge, only the short-circuit check can cut discharge. During over-discharge, the charge over-current check is off.

Top module: `bpm_protect_ctrl`

## Requirements
- R1: After a synchronous reset the block is in normal mode. In this mode `chg_sw_en`=1, `dchg_sw_en`=1, `sense_pullup_en`=0, `sense_pulldown_en`=0 and `standby`=0. The outputs are registered and change on the clock edge that completes a count.
- R2: In normal mode, if `cell_over_v` is high for `T_OVCHG` ticks, `chg_sw_en` drops and `dchg_sw_en` stays on. The block returns to normal after `charger_present`=0 and `cell_below_ovrel`=1 have both held for `T_OVREL` ticks.
- R3: In normal mode, if `cell_under_v` is high for `T_UNDERV` ticks, the block enters standby. In standby `dchg_sw_en`=0, `sense_pullup_en`=1, `standby`=1 and `chg_sw_en`=1.
- R4: In standby, a high `charger_present` at a clock edge gives `dchg_sw_en`=1, `sense_pullup_en`=0 and `standby`=0. With no charger, a high `cell_above_wake` returns the block straight to normal. If the charger leaves before release, the block goes back to standby.
- R5: Once standby has been left through a charger, the block returns to normal only after `cell_above_uvrel` has held for `T_UVREL` ticks.
- R6: From standby until that release, `sense_chg_oc` has no effect.
- R7: In normal mode, `sense_dis_oc` held for `T_DISOC` ticks gives `dchg_sw_en`=0 and `sense_pulldown_en`=1, with `chg_sw_en`=1.
- R8: In normal mode, `sense_short` held for `T_SHORT` ticks gives the same outputs as R7.
- R9: Recovery from R7 or R8 needs `load_present`=0 and `sense_below_dis_rel`=1 held together for `T_DISREL` ticks. The block then returns to normal.
- R10: During over-charge, `sense_dis_oc` is ignored. `sense_short` held for `T_SHORT` ticks gives `chg_sw_en`=0, `dchg_sw_en`=0 and `sense_pulldown_en`=1. The R9 release then returns the block to over-charge, not to normal.
- R11: In normal mode, `sense_chg_oc` held for `T_CHGOC` ticks drops `chg_sw_en`. Recovery needs `charger_present`=0 and `sense_above_chg_rel`=1 held together for `T_CHGREL` ticks.
- R12: A delay advances only on a tick while its condition is true. It restarts from zero whenever the condition is false on a clock edge.
- R13: If several counts in normal mode complete on the same edge, the winner is chosen in this order: short circuit, discharge over-current, under-voltage, over-voltage, charge over-current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable for all delay counts |
| cell_over_v | input | 1 | Cell at or above over-charge threshold |
| cell_below_ovrel | input | 1 | Cell below over-charge release level |
| cell_under_v | input | 1 | Cell below over-discharge threshold |
| cell_above_uvrel | input | 1 | Cell above over-discharge release level |
| cell_above_wake | input | 1 | Cell above the auto wake-up level |
| sense_dis_oc | input | 1 | Sense at or above discharge over-current threshold |
| sense_short | input | 1 | Sense at or above short-circuit threshold |
| sense_below_dis_rel | input | 1 | Sense at or below discharge release level |
| sense_chg_oc | input | 1 | Sense at or below charge over-current limit |
| sense_above_chg_rel | input | 1 | Sense at or above charge over-current release level |
| charger_present | input | 1 | Charger detected |
| load_present | input | 1 | Load detected |
| chg_sw_en | output | 1 | Charge switch enable |
| dchg_sw_en | output | 1 | Discharge switch enable |
| sense_pullup_en | output | 1 | Sense-node pull-up enable |
| sense_pulldown_en | output | 1 | Sense-node pull-down enable |
| standby | output | 1 | Standby, internal bias off |

## Verification
Directed sequences drive each fault flag for one tick short of its count and then for the full count. This separates a trip that comes on time from one that comes early or late. A break in the condition, and pauses of the tick, show whether a count restarts or merely pauses. Recovery is tried with the blocking condition (charger or load) still present and then with it removed. Both over-discharge entries use a charger-exit path, and each is followed by a charge over-current trip attempt, which shows whether the release really happened. Faults are started at staggered times so that their counts finish on the same edge, which exposes the priority order. Slowly toggling random flags with a random tick then stress mode changes against a reference model.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    typedef enum logic [2:0] {
        M_NORMAL,
        M_OVCHG,
        M_OVCHG_SHORT,
        M_UNDERV,
        M_UNDERV_CHG,
        M_DISCH_OC,
        M_CHG_OC
    } mode_e;

    typedef struct packed {
        logic chg_en;
        logic dchg_en;
        logic pullup_en;
        logic pulldown_en;
        logic standby;
    } drive_t;

    typedef struct packed {
        logic ov;
        logic ovrel_below;
        logic uv;
        logic uvrel_above;
        logic wake_above;
        logic dis_oc;
        logic shortc;
        logic disrel_low;
        logic chg_oc;
        logic chgrel_high;
        logic charger;
        logic load;
    } sense_t;

    localparam int NDLY      = 9;
    localparam int DL_OV     = 0;
    localparam int DL_OVREL  = 1;
    localparam int DL_UV     = 2;
    localparam int DL_UVREL  = 3;
    localparam int DL_DISOC  = 4;
    localparam int DL_SHORT  = 5;
    localparam int DL_DISREL = 6;
    localparam int DL_CHGOC  = 7;
    localparam int DL_CHGREL = 8;

    function automatic drive_t drive_of(mode_e m);
        drive_t d;
        d = '{chg_en: 1'b1, dchg_en: 1'b1, pullup_en: 1'b0, pulldown_en: 1'b0, standby: 1'b0};
        case (m)
            M_OVCHG:       d.chg_en = 1'b0;
            M_OVCHG_SHORT: begin d.chg_en = 1'b0; d.dchg_en = 1'b0; d.pulldown_en = 1'b1; end
            M_UNDERV:      begin d.dchg_en = 1'b0; d.pullup_en = 1'b1; d.standby = 1'b1; end
            M_DISCH_OC:    begin d.dchg_en = 1'b0; d.pulldown_en = 1'b1; end
            M_CHG_OC:      d.chg_en = 1'b0;
            default:       ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bpm_delay_counter.sv
module bpm_delay_counter #(
    parameter int unsigned LIMIT = 4,
    parameter int          CW    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic qual,
    output logic done
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = qual && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !qual) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R12: a partial count can only exist if the condition held on the previous edge
    a_r12_need_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $past(qual));

    // R12: the count never passes its terminal value
    a_r12_bounded: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) < LIMIT);

endmodule

// File: rtl/bpm_qualify.sv
module bpm_qualify
    import bpm_pkg::*;
(
    input  mode_e           mode,
    input  sense_t          s,
    output logic [NDLY-1:0] qual
);
    always_comb begin
        qual             = '0;
        qual[DL_OV]      = (mode == M_NORMAL) && s.ov;
        qual[DL_OVREL]   = (mode == M_OVCHG) && !s.charger && s.ovrel_below;
        qual[DL_UV]      = (mode == M_NORMAL) && s.uv;
        qual[DL_UVREL]   = (mode == M_UNDERV_CHG) && s.uvrel_above;
        qual[DL_DISOC]   = (mode == M_NORMAL) && s.dis_oc;
        qual[DL_SHORT]   = ((mode == M_NORMAL) || (mode == M_OVCHG)) && s.shortc;
        qual[DL_DISREL]  = ((mode == M_DISCH_OC) || (mode == M_OVCHG_SHORT))
                           && !s.load && s.disrel_low;
        qual[DL_CHGOC]   = (mode == M_NORMAL) && s.chg_oc;
        qual[DL_CHGREL]  = (mode == M_CHG_OC) && !s.charger && s.chgrel_high;
    end
endmodule

// File: rtl/bpm_mode_fsm.sv
module bpm_mode_fsm
    import bpm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NDLY-1:0] done,
    input  logic            charger,
    input  logic            wake,
    output mode_e           mode,
    output drive_t          drv
);
    mode_e mode_n;

    always_comb begin
        mode_n = mode;
        case (mode)
            M_NORMAL: begin
                if (done[DL_SHORT])      mode_n = M_DISCH_OC;
                else if (done[DL_DISOC]) mode_n = M_DISCH_OC;
                else if (done[DL_UV])    mode_n = M_UNDERV;
                else if (done[DL_OV])    mode_n = M_OVCHG;
                else if (done[DL_CHGOC]) mode_n = M_CHG_OC;
            end
            M_OVCHG: begin
                if (done[DL_SHORT])      mode_n = M_OVCHG_SHORT;
                else if (done[DL_OVREL]) mode_n = M_NORMAL;
            end
            M_OVCHG_SHORT: if (done[DL_DISREL]) mode_n = M_OVCHG;
            M_UNDERV: begin
                if (charger)   mode_n = M_UNDERV_CHG;
                else if (wake) mode_n = M_NORMAL;
            end
            M_UNDERV_CHG: begin
                if (done[DL_UVREL]) mode_n = M_NORMAL;
                else if (!charger)  mode_n = M_UNDERV;
            end
            M_DISCH_OC: if (done[DL_DISREL]) mode_n = M_NORMAL;
            M_CHG_OC:   if (done[DL_CHGREL]) mode_n = M_NORMAL;
            default:    mode_n = M_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= M_NORMAL;
            drv  <= drive_of(M_NORMAL);
        end else begin
            mode <= mode_n;
            drv  <= drive_of(mode_n);
        end
    end

    // R2: entry into over-charge only on a completed over-voltage count
    a_r2_ov_entry: assert property (@(posedge clk) disable iff (rst)
        (mode == M_OVCHG && $past(mode) == M_NORMAL) |-> $past(done[DL_OV]));

    // R4: a charger seen in standby always brings the block out to the charging sub-mode
    a_r4_charger_exit: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == M_UNDERV && $past(charger)) |-> (mode == M_UNDERV_CHG));

    // R6: no charge over-current trip straight out of the over-discharge charging sub-mode
    a_r6_no_chgoc: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == M_UNDERV_CHG) |-> (mode != M_CHG_OC));

    // R10: leaving the short trip taken during over-charge lands in over-charge
    a_r10_short_return: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == M_OVCHG_SHORT && mode != M_OVCHG_SHORT) |-> (mode == M_OVCHG));

endmodule

// File: rtl/bpm_protect_ctrl.sv
module bpm_protect_ctrl
    import bpm_pkg::*;
#(
    parameter int unsigned T_OVCHG  = 10000,
    parameter int unsigned T_OVREL  = 160,
    parameter int unsigned T_UNDERV = 200,
    parameter int unsigned T_UVREL  = 11,
    parameter int unsigned T_DISOC  = 120,
    parameter int unsigned T_SHORT  = 4,
    parameter int unsigned T_DISREL = 40,
    parameter int unsigned T_CHGOC  = 160,
    parameter int unsigned T_CHGREL = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cell_over_v,
    input  logic cell_below_ovrel,
    input  logic cell_under_v,
    input  logic cell_above_uvrel,
    input  logic cell_above_wake,
    input  logic sense_dis_oc,
    input  logic sense_short,
    input  logic sense_below_dis_rel,
    input  logic sense_chg_oc,
    input  logic sense_above_chg_rel,
    input  logic charger_present,
    input  logic load_present,
    output logic chg_sw_en,
    output logic dchg_sw_en,
    output logic sense_pullup_en,
    output logic sense_pulldown_en,
    output logic standby
);
    function automatic int unsigned lim_sel(int idx);
        case (idx)
            DL_OV:     return T_OVCHG;
            DL_OVREL:  return T_OVREL;
            DL_UV:     return T_UNDERV;
            DL_UVREL:  return T_UVREL;
            DL_DISOC:  return T_DISOC;
            DL_SHORT:  return T_SHORT;
            DL_DISREL: return T_DISREL;
            DL_CHGOC:  return T_CHGOC;
            default:   return T_CHGREL;
        endcase
    endfunction

    function automatic int unsigned lim_max();
        int unsigned m = 1;
        for (int i = 0; i < NDLY; i++) begin
            if (lim_sel(i) > m) m = lim_sel(i);
        end
        return m;
    endfunction

    localparam int CW = $clog2(lim_max() + 1);

    sense_t          s;
    mode_e           mode;
    drive_t          drv;
    logic [NDLY-1:0] qual;
    logic [NDLY-1:0] done;

    assign s = '{ov: cell_over_v, ovrel_below: cell_below_ovrel, uv: cell_under_v,
                 uvrel_above: cell_above_uvrel, wake_above: cell_above_wake,
                 dis_oc: sense_dis_oc, shortc: sense_short, disrel_low: sense_below_dis_rel,
                 chg_oc: sense_chg_oc, chgrel_high: sense_above_chg_rel,
                 charger: charger_present, load: load_present};

    bpm_qualify u_qual (.mode(mode), .s(s), .qual(qual));

    for (genvar g = 0; g < NDLY; g++) begin : g_dly
        bpm_delay_counter #(.LIMIT(lim_sel(g)), .CW(CW)) u_cnt (
            .clk(clk), .rst(rst), .tick(tick), .qual(qual[g]), .done(done[g])
        );
    end

    bpm_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .done(done), .charger(charger_present),
        .wake(cell_above_wake), .mode(mode), .drv(drv)
    );

    assign chg_sw_en         = drv.chg_en;
    assign dchg_sw_en        = drv.dchg_en;
    assign sense_pullup_en   = drv.pullup_en;
    assign sense_pulldown_en = drv.pulldown_en;
    assign standby           = drv.standby;

    // R3: standby always comes with the pull-up on and the discharge path off
    a_r3_standby_shape: assert property (@(posedge clk) disable iff (rst)
        standby |-> (sense_pullup_en && !dchg_sw_en));

    // R7: pull-up and pull-down are never on together
    a_r7_pull_excl: assert property (@(posedge clk) disable iff (rst)
        !(sense_pullup_en && sense_pulldown_en));

endmodule

// File: tb/bpm_protect_ctrl_test.sv
`timescale 1ns/1ps
module bpm_protect_ctrl_test;
    localparam int unsigned L_OV = 5, L_OVR = 3, L_UV = 4, L_UVR = 2, L_OC1 = 4,
                            L_SC = 2, L_DR = 3, L_COC = 4, L_CR = 3;
    localparam int B_NORM = 0, B_OVC = 1, B_OVSC = 2, B_UV = 3, B_UVC = 4, B_DOC = 5, B_COC = 6;

    logic clk = 1'b0, rst = 1'b1, tick = 1'b1;
    logic ov = 0, ovr = 0, uv = 0, uvr = 0, wake = 0, oc1 = 0, sc = 0, drl = 0, coc = 0,
          crh = 0, chg = 0, load = 0;
    logic o_chg, o_dchg, o_pu, o_pd, o_stby;

    int checks = 0, failures = 0;
    bit finished = 0;
    int m_mode;
    int unsigned cnt [9];
    int unsigned lim [9] = '{L_OV, L_OVR, L_UV, L_UVR, L_OC1, L_SC, L_DR, L_COC, L_CR};

    always #2 clk = ~clk;

    bpm_protect_ctrl #(.T_OVCHG(L_OV), .T_OVREL(L_OVR), .T_UNDERV(L_UV), .T_UVREL(L_UVR),
        .T_DISOC(L_OC1), .T_SHORT(L_SC), .T_DISREL(L_DR), .T_CHGOC(L_COC), .T_CHGREL(L_CR)) uut (
        .clk(clk), .rst(rst), .tick(tick), .cell_over_v(ov), .cell_below_ovrel(ovr),
        .cell_under_v(uv), .cell_above_uvrel(uvr), .cell_above_wake(wake),
        .sense_dis_oc(oc1), .sense_short(sc), .sense_below_dis_rel(drl),
        .sense_chg_oc(coc), .sense_above_chg_rel(crh), .charger_present(chg),
        .load_present(load), .chg_sw_en(o_chg), .dchg_sw_en(o_dchg),
        .sense_pullup_en(o_pu), .sense_pulldown_en(o_pd), .standby(o_stby));

    // expected {chg, dchg, pullup, pulldown, standby} per reference mode
    function automatic logic [4:0] exp_out(int m);
        case (m)
            B_OVC, B_COC: return 5'b01000;
            B_OVSC:       return 5'b00010;
            B_UV:         return 5'b10101;
            B_DOC:        return 5'b10010;
            default:      return 5'b11000;
        endcase
    endfunction

    task automatic model_step();
        bit q [9];
        bit d [9];
        int nm;
        q[0] = (m_mode == B_NORM) && ov;
        q[1] = (m_mode == B_OVC) && !chg && ovr;
        q[2] = (m_mode == B_NORM) && uv;
        q[3] = (m_mode == B_UVC) && uvr;
        q[4] = (m_mode == B_NORM) && oc1;
        q[5] = (m_mode == B_NORM || m_mode == B_OVC) && sc;
        q[6] = (m_mode == B_DOC || m_mode == B_OVSC) && !load && drl;
        q[7] = (m_mode == B_NORM) && coc;
        q[8] = (m_mode == B_COC) && !chg && crh;
        for (int i = 0; i < 9; i++) begin
            d[i] = q[i] && tick && (cnt[i] == lim[i] - 1);
            if (!q[i]) cnt[i] = 0;
            else if (tick) cnt[i] = d[i] ? 0 : cnt[i] + 1;
        end
        nm = m_mode;
        case (m_mode)
            B_NORM: if (d[5] || d[4]) nm = B_DOC; else if (d[2]) nm = B_UV;
                    else if (d[0]) nm = B_OVC; else if (d[7]) nm = B_COC;
            B_OVC:  if (d[5]) nm = B_OVSC; else if (d[1]) nm = B_NORM;
            B_OVSC: if (d[6]) nm = B_OVC;
            B_UV:   if (chg) nm = B_UVC; else if (wake) nm = B_NORM;
            B_UVC:  if (d[3]) nm = B_NORM; else if (!chg) nm = B_UV;
            B_DOC:  if (d[6]) nm = B_NORM;
            default: if (d[8]) nm = B_NORM;
        endcase
        m_mode = nm;
    endtask

    task automatic check(string tag, logic [4:0] expv);
        logic [4:0] act;
        act = {o_chg, o_dchg, o_pu, o_pd, o_stby};
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, expv);
        end
    endtask

    task automatic cyc(string tag, int n = 1);
        for (int k = 0; k < n; k++) begin
            model_step();
            @(posedge clk);
            @(negedge clk);
            check(tag, exp_out(m_mode));
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2468));
        m_mode = B_NORM;
        for (int i = 0; i < 9; i++) cnt[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 reset", 5'b11000);

        // R12 restart and R2 detection
        ov = 1; cyc("R12", 3); ov = 0; cyc("R12");
        ov = 1; cyc("R12", 4); check("R12 restart", 5'b11000);
        cyc("R2"); check("R2 trip", 5'b01000);
        ov = 0; ovr = 1; chg = 1; cyc("R2", 5); check("R2 charger blocks", 5'b01000);
        chg = 0; cyc("R2", 3); check("R2 release", 5'b11000); ovr = 0;
        // R12 tick gating
        ov = 1; tick = 0; cyc("R12", 6); check("R12 no tick", 5'b11000);
        tick = 1; cyc("R12", 5); check("R12 tick trip", 5'b01000);
        // R10 in over-charge
        ov = 0; oc1 = 1; cyc("R10", 6); check("R10 oc1 masked", 5'b01000);
        sc = 1; cyc("R10", 2); check("R10 short", 5'b00010);
        sc = 0; oc1 = 0; load = 1; drl = 1; cyc("R10", 4); check("R10 load blocks", 5'b00010);
        load = 0; cyc("R10", 3); check("R10 return", 5'b01000);
        drl = 0; ovr = 1; cyc("R2", 3); ovr = 0; check("R2 back", 5'b11000);
        // R7, R8, R9
        oc1 = 1; cyc("R7", 4); check("R7 trip", 5'b10010);
        oc1 = 0; drl = 1; cyc("R9", 3); check("R9 release", 5'b11000); drl = 0;
        sc = 1; cyc("R8", 2); check("R8 trip", 5'b10010);
        sc = 0; drl = 1; cyc("R9", 2); drl = 0; cyc("R9"); drl = 1; cyc("R9", 2);
        check("R9 restart", 5'b10010); cyc("R9"); check("R9 release2", 5'b11000); drl = 0;
        // R11
        coc = 1; cyc("R11", 4); check("R11 trip", 5'b01000);
        coc = 0; crh = 1; chg = 1; cyc("R11", 4); check("R11 charger blocks", 5'b01000);
        chg = 0; cyc("R11", 3); check("R11 release", 5'b11000); crh = 0;
        // R3, R4, R6
        uv = 1; cyc("R3", 4); check("R3 standby", 5'b10101);
        coc = 1; chg = 1; cyc("R4"); check("R4 charger exit", 5'b11000);
        cyc("R6", 6); check("R6 chgoc ignored", 5'b11000);
        coc = 0; chg = 0; cyc("R4"); check("R4 charger gone", 5'b10101);
        uv = 0; wake = 1; cyc("R4"); check("R4 wake", 5'b11000); wake = 0;
        // R5
        uv = 1; cyc("R5", 4); uv = 0; chg = 1; cyc("R5"); uvr = 1; cyc("R5", 2);
        chg = 0; uvr = 0; coc = 1; cyc("R5", 4); check("R5 released", 5'b01000);
        coc = 0; crh = 1; cyc("R11", 3); crh = 0;
        // R13 priority
        ov = 1; cyc("R13"); uv = 1; cyc("R13", 4); check("R13 uv over ov", 5'b10101);
        ov = 0; uv = 0; wake = 1; cyc("R4"); wake = 0;
        oc1 = 1; uv = 1; cyc("R13", 4); check("R13 oc1 over uv", 5'b10010);
        oc1 = 0; uv = 0; drl = 1; cyc("R9", 3); drl = 0;

        // random phase against reference model
        for (int n = 0; n < 6000; n++) begin
            tick = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 9) == 0) ov = ~ov;
            if ($urandom_range(0, 9) == 0) ovr = ~ovr;
            if ($urandom_range(0, 12) == 0) uv = ~uv;
            if ($urandom_range(0, 9) == 0) uvr = ~uvr;
            if ($urandom_range(0, 15) == 0) wake = ~wake;
            if ($urandom_range(0, 12) == 0) oc1 = ~oc1;
            if ($urandom_range(0, 15) == 0) sc = ~sc;
            if ($urandom_range(0, 7) == 0) drl = ~drl;
            if ($urandom_range(0, 12) == 0) coc = ~coc;
            if ($urandom_range(0, 7) == 0) crh = ~crh;
            if ($urandom_range(0, 9) == 0) chg = ~chg;
            if ($urandom_range(0, 9) == 0) load = ~load;
            cyc("random model");
        end
        finish_run();
    end
endmodule